// File: doc/BRIEF.md
# Parallel/serial-in serial-out shift register

This block is an eight-stage register built from edge-triggered storage elements. It has one serial data input, one parallel jam input per stage, a shared clock and a mode control. When the mode control is low, the register shifts toward the last stage on every rising clock edge. When the mode control is high, the register takes the jam word instead. The outputs are taps on stages 6, 7 and 8.

A build-time parameter picks how the jam load is timed. In the clocked variant, the load happens on the rising clock edge. In the forced variant, the load happens as soon as the mode control rises, and the clock does nothing while the control stays high. Serial shifting is clocked in both variants.

Longer registers are made by driving the next unit's serial input from this unit's last-stage tap, with the clock and mode control shared.

Top module: `jam_shift_reg`

## Requirements
- R1: While `rst_n` is low, every stage is zero. Reset acts at once, without a clock edge, and has priority over both jam load and shift.
- R2: With `mode_load` low at a rising clock edge, stage 1 takes `ser_in` and each stage k>1 takes the value stage k-1 held before the edge.
- R3: With `ASYNC_LOAD`=0, a high `mode_load` at a rising clock edge loads `par_in` into all stages. Raising `mode_load` between edges leaves the stages unchanged until that edge.
- R4: With `ASYNC_LOAD`=1, a rise of `mode_load` loads `par_in` into all stages without waiting for a clock edge. Clock edges while `mode_load` stays high leave that content in place. `par_in` is held stable while `mode_load` is high.
- R5: With `ASYNC_LOAD`=1, after `mode_load` falls the stages keep the loaded word until the next rising edge, and then they shift as in R2.
- R6: Bit `par_in[k-1]` loads stage k. After a load, `tap_last` shows `par_in[7]`, and each later shift brings out `par_in[6]`, then `par_in[5]`, and so on.
- R7: `tap_a`, `tap_b` and `tap_last` show stages 6, 7 and 8 at all times.
- R8: Two units chained (second `ser_in` driven by the first `tap_last`, with shared clock, mode and jam word) behave as one 16-stage register. The second unit's `tap_last` is its own stage 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode_load | input | 1 | 1 = jam load from par_in, 0 = serial shift |
| ser_in | input | 1 | Serial data into stage 1 |
| par_in | input | STAGES | Jam word; bit k-1 feeds stage k |
| tap_a | output | 1 | Stage 6 content |
| tap_b | output | 1 | Stage 7 content |
| tap_last | output | 1 | Last-stage content; used for chaining |

## Verification
The bench raises `mode_load` in the middle of a clock period and looks at the taps before the next edge.

- Clocked variant: the taps must not move yet. A design that loaded early here would fail.
- Forced variant: the taps must already show the jam word. A design whose forced load waits for the clock would fail here.

Holding the control high across several edges catches a forced variant that shifts or reloads while it is held. The first cycle after the control falls catches one that drops the loaded word. Jam words with different first and last bits, shifted all the way out, catch a reversed bit order. A cascaded pair catches a last stage that does not feed the chain. A jam request made during reset catches load taking priority over the clear.

// File: rtl/jsr_pkg.sv
package jsr_pkg;

  typedef enum logic {
    ENTRY_SHIFT = 1'b0,
    ENTRY_JAM   = 1'b1
  } entry_e;

  // Select which source a stage captures.
  function automatic entry_e entry_of(input logic mode_hi);
    return mode_hi ? ENTRY_JAM : ENTRY_SHIFT;
  endfunction

  // Next value of one stage given its entry kind.
  function automatic logic stage_next(input entry_e kind,
                                      input logic   upstream,
                                      input logic   jam);
    return (kind == ENTRY_JAM) ? jam : upstream;
  endfunction

endpackage

// File: rtl/jsr_stage.sv
module jsr_stage
  import jsr_pkg::*;
#(
  parameter int ASYNC_LOAD = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic upstream,
  input  logic jam,
  output logic q
);

  generate
    if (ASYNC_LOAD != 0) begin : g_forced
      // A rising load writes the jam bit at once; while load is high,
      // a clock edge rewrites the same (stable) jam bit.
      always_ff @(posedge clk or negedge rst_n or posedge load) begin
        if (!rst_n)    q <= 1'b0;
        else if (load) q <= jam;
        else           q <= upstream;
      end
    end else begin : g_clocked
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= stage_next(entry_of(load), upstream, jam);
      end
    end
  endgenerate

endmodule

// File: rtl/jsr_tap.sv
module jsr_tap #(
  parameter int WIDTH = 8,
  parameter int INDEX = 8
) (
  input  logic [WIDTH-1:0] vec,
  output logic             bit_o
);

  localparam int POS = INDEX - 1;

  assign bit_o = vec[POS];

endmodule

// File: rtl/jam_shift_reg.sv
module jam_shift_reg #(
  parameter int STAGES     = 8,
  parameter int ASYNC_LOAD = 0,
  parameter int TAP_A      = 6,
  parameter int TAP_B      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic              ser_in,
  input  logic [STAGES-1:0] par_in,
  output logic              tap_a,
  output logic              tap_b,
  output logic              tap_last
);

  localparam int LAST = STAGES;

  logic [STAGES-1:0] st;
  logic [STAGES-1:0] feed;

  // Named events for the checker.
  logic shift_evt;
  logic load_evt;
  assign shift_evt = rst_n & ~mode_load;
  assign load_evt  = rst_n &  mode_load;

  assign feed[0] = ser_in;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k > 0) begin : g_link
        assign feed[k] = st[k-1];
      end
      jsr_stage #(.ASYNC_LOAD(ASYNC_LOAD)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mode_load),
        .upstream (feed[k]),
        .jam      (par_in[k]),
        .q        (st[k])
      );
    end
  endgenerate

  jsr_tap #(.WIDTH(STAGES), .INDEX(TAP_A)) u_tap_a (.vec(st), .bit_o(tap_a));
  jsr_tap #(.WIDTH(STAGES), .INDEX(TAP_B)) u_tap_b (.vec(st), .bit_o(tap_b));
  jsr_tap #(.WIDTH(STAGES), .INDEX(LAST))  u_tap_l (.vec(st), .bit_o(tap_last));

endmodule

// File: rtl/jsr_checker.sv
module jsr_checker #(
  parameter int STAGES     = 8,
  parameter int ASYNC_LOAD = 0,
  parameter int TAP_A      = 6,
  parameter int TAP_B      = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_load,
  input logic              ser_in,
  input logic [STAGES-1:0] par_in,
  input logic [STAGES-1:0] st,
  input logic              tap_a,
  input logic              tap_b,
  input logic              tap_last,
  input logic              shift_evt,
  input logic              load_evt
);

  localparam logic FORCED = (ASYNC_LOAD != 0);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (st == '0));

  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (load_evt || st == {$past(st[STAGES-2:0]), $past(ser_in)}));

  assert_jam_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (st == $past(par_in)));

  assert_forced_jam_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (FORCED && mode_load) |-> (st == par_in));

  assert_tap_view_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_last == st[STAGES-1]) && (tap_a == st[TAP_A-1]) && (tap_b == st[TAP_B-1]));

endmodule

bind jam_shift_reg jsr_checker #(
  .STAGES(STAGES), .ASYNC_LOAD(ASYNC_LOAD), .TAP_A(TAP_A), .TAP_B(TAP_B)
) u_jsr_checker (
  .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .ser_in(ser_in),
  .par_in(par_in), .st(st), .tap_a(tap_a), .tap_b(tap_b),
  .tap_last(tap_last), .shift_evt(shift_evt), .load_evt(load_evt)
);

// File: tb/jam_shift_reg_bench.sv
module jam_shift_reg_bench;

  localparam int PERIOD = 10;

  typedef struct {
    logic [7:0] m;
    logic [7:0] mc;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       mode_load = 1'b0;
  logic       ser_in = 1'b0;
  logic [7:0] par_in = '0;

  logic s_a, s_b, s_l;
  logic f_a, f_b, f_l;
  logic c_a, c_b, c_l;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m  = '0;
  logic [7:0] mc = '0;
  exp_t q[$];

  always #(PERIOD/2) clk = ~clk;

  jam_shift_reg #(.ASYNC_LOAD(0)) u_jam_shift_reg (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .ser_in(ser_in),
    .par_in(par_in), .tap_a(s_a), .tap_b(s_b), .tap_last(s_l));

  jam_shift_reg #(.ASYNC_LOAD(1)) u_jam_shift_reg_forced (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .ser_in(ser_in),
    .par_in(par_in), .tap_a(f_a), .tap_b(f_b), .tap_last(f_l));

  // R8: second unit fed from the first unit's last stage
  jam_shift_reg #(.ASYNC_LOAD(0)) u_jam_shift_reg_chain (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .ser_in(s_l),
    .par_in(par_in), .tap_a(c_a), .tap_b(c_b), .tap_last(c_l));

  task automatic chk(input string req, input string who,
                     input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s taps actual=%b expected=%b at %0t", req, who, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] taps_of(input logic [7:0] v);
    return {v[5], v[6], v[7]};
  endfunction

  // Driver: drive just after a falling edge, check mid-period, queue post-edge view.
  task automatic step(input logic ld, input logic s, input logic [7:0] p, input string tag);
    exp_t e;
    logic last_before;
    @(negedge clk);
    #1;
    mode_load = ld;
    ser_in    = s;
    par_in    = p;
    #1;
    if (ld) begin
      chk("R3", "clocked-mid", {s_a, s_b, s_l}, taps_of(m));
      chk("R4", "forced-mid",  {f_a, f_b, f_l}, taps_of(p));
    end else begin
      chk("R5", "forced-mid",  {f_a, f_b, f_l}, taps_of(m));
    end
    last_before = m[7];
    if (ld) begin
      m  = p;
      mc = p;
    end else begin
      m  = {m[6:0], s};
      mc = {mc[6:0], last_before};
    end
    e.m = m; e.mc = mc; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare queued expectations away from the rising edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "clocked", {s_a, s_b, s_l}, taps_of(e.m));
      chk(e.tag, "forced",  {f_a, f_b, f_l}, taps_of(e.m));
      chk("R8",  "chain",   {c_a, c_b, c_l}, taps_of(e.mc));
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic       prev_ld;
    logic [7:0] prev_p;
    #1 rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk("R1", "clocked-reset", {s_a, s_b, s_l}, 3'b000);
    chk("R1", "forced-reset",  {f_a, f_b, f_l}, 3'b000);
    // R1: jam request during reset must not win over the clear
    mode_load = 1'b1; par_in = 8'hFF; ser_in = 1'b1;
    @(negedge clk);
    chk("R1", "clocked-prio", {s_a, s_b, s_l}, 3'b000);
    chk("R1", "forced-prio",  {f_a, f_b, f_l}, 3'b000);
    chk("R1", "chain-prio",   {c_a, c_b, c_l}, 3'b000);
    #1 mode_load = 1'b0; par_in = '0; ser_in = 1'b0;
    @(negedge clk);
    #1 rst_n = 1'b1;

    // R2: plain serial fill
    step(1'b0, 1'b1, 8'h00, "R2");
    step(1'b0, 1'b0, 8'h00, "R2");
    for (int i = 0; i < 8; i++) step(1'b0, 1'(i % 3 == 0), 8'h00, "R2");

    // R6: bit order through shift-out, with distinct end bits
    step(1'b1, 1'b0, 8'h2D, "R6");
    for (int i = 0; i < 9; i++) step(1'b0, 1'b0, 8'h00, "R6");

    // R4/R5: hold the load over several edges, then release
    step(1'b1, 1'b1, 8'hC3, "R4");
    step(1'b1, 1'b1, 8'hC3, "R4");
    step(1'b1, 1'b0, 8'hC3, "R4");
    step(1'b0, 1'b1, 8'h00, "R5");
    step(1'b0, 1'b0, 8'h5A, "R5");

    // R7/R3: random mix; par_in held while load stays high
    prev_ld = 1'b0;
    prev_p  = 8'h00;
    for (int i = 0; i < 800; i++) begin
      logic       ld;
      logic [7:0] p;
      ld = ($urandom_range(0, 3) == 0);
      p  = 8'($urandom());
      if (ld && prev_ld) p = prev_p;
      step(ld, 1'($urandom()), p, ld ? "R3" : "R7");
      prev_ld = ld;
      prev_p  = p;
    end

    @(negedge clk);
    #1;
    finish_run();
  end

endmodule